// File: doc/BRIEF.md
# Reorder Buffer With In-Order Commit

This block keeps program order for an out-of-order core. Every issued instruction takes the next entry of a circular buffer, and the index of that entry goes back to the issue stage as the tag that its result will carry. Execution units finish in any order and broadcast a tag, a value and two status flags on a result bus. The matching entry stores the value and becomes ready. Retirement happens only at the oldest entry. A register operation retires into a register file write port. A store retires into a memory write port, so the buffer also holds pending stores. A correctly predicted branch retires without writing anything.

Faults are never acted on where they occur. An exception flag or a branch-mispredict flag is held in its entry. It takes effect only when that entry is the oldest one, so every older instruction has already retired and no younger one has. At that point the whole buffer is emptied and a one-cycle flush pulse gives the restart address. Up to two entries retire per clock. While an entry is ready but not yet retired, its value can be read through a tag-addressed operand port.

Top module: `retire_buffer`

## Requirements
- R1: After reset, alloc_ready is 1, alloc_tag is 0, and every write enable and the flush output are 0. An allocation is accepted in a cycle with alloc_valid=1 and alloc_ready=1. Accepted allocations receive consecutive tags counting up from 0 modulo DEPTH, and alloc_tag always shows the tag of the next allocation.
- R2: Once DEPTH entries are live, alloc_ready is 0 and a request is ignored. alloc_ready returns to 1 in the cycle after an entry retires.
- R3: A result with res_valid=1 whose res_tag names a live entry stores res_value and marks that entry ready. It also records res_excp and res_misp in the entry. A result whose tag names no live entry has no effect.
- R4: Only the oldest entry retires first, and only once it is ready. A ready younger entry waits behind a head entry that is not ready.
- R5: alloc_kind encodes the entry type: 0 is a register operation, 1 is a store, 2 is a branch. A retiring register operation pulses rf_we with rf_waddr equal to the low REG_W bits of its destination and rf_wdata equal to its value. A retiring store pulses mem_we with mem_addr equal to its destination and mem_data equal to its value. A correct branch writes nothing. These outputs appear one clock after the cycle in which the entry is ready at the head.
- R6: A branch at the head that is ready and carries the mispredict flag causes the following: a one-cycle flush with flush_excp=0 and flush_target equal to the branch value, no write, and removal of every entry. The next allocation then gets tag 0.
- R7: An entry that is ready with the exception flag set raises nothing until it is the head. It then causes a one-cycle flush with flush_excp=1 and flush_target=EXC_VECTOR. Its own write is suppressed and every entry is removed.
- R8: The tag on rd_tag is sampled at a clock edge. After that edge, rd_hit is 1 and rd_value is the stored value if the entry was live and ready; otherwise rd_hit is 0.
- R9: Two entries retire in one clock when both head entries are ready, the older one retires normally and the younger one is not a flush case. Lane 0 always carries the older entry.
- R10: An exception or mispredict entry in second place does not retire alongside the head. It flushes one clock later, once it has become the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate an entry |
| alloc_kind | input | 2 | Entry type: 0 register op, 1 store, 2 branch |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tag | output | IDX_W | Tag given to the next allocation |
| res_valid | input | 1 | Result bus strobe |
| res_tag | input | IDX_W | Tag of the finishing entry |
| res_value | input | DATA_W | Result, store data or branch target |
| res_excp | input | 1 | Entry raised an exception |
| res_misp | input | 1 | Branch was mispredicted |
| rd_tag | input | IDX_W | Operand lookup tag |
| rd_hit | output | 1 | Looked-up entry is live and ready |
| rd_value | output | DATA_W | Value of looked-up entry |
| rf_we | output | 2 | Register write enable per lane |
| rf_waddr | output | 2 x REG_W | Register number per lane |
| rf_wdata | output | 2 x DATA_W | Register data per lane |
| mem_we | output | 2 | Memory write enable per lane |
| mem_addr | output | 2 x DEST_W | Store address per lane |
| mem_data | output | 2 x DATA_W | Store data per lane |
| flush | output | 1 | One-cycle flush pulse |
| flush_excp | output | 1 | Flush came from an exception |
| flush_target | output | DATA_W | Restart address |

## Verification
The assertions check several properties on every cycle. The live-entry count never exceeds DEPTH and always equals the population of valid bits. A full buffer stays full unless something retires. A dual retirement needs two live entries. A waiting head causes no write, and a flush leaves the buffer empty. Only the bench scenarios can show the end-to-end behaviour. These cover the retirement order and data after results arrive in reverse order, a full buffer refusing a request, and a wrong-path entry never being written after a mispredict. They also cover an exception in second place flushing exactly one clock after the head retires, and a result sent to a tag that is not live being dropped.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } rkind_e;

  // An entry that ends the current program path instead of retiring.
  function automatic logic flush_type(logic [1:0] kind, logic excp, logic misp);
    return excp | ((kind == K_BRANCH) & misp);
  endfunction
endpackage

// File: rtl/retire_ptrs.sv
module retire_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_alloc,
  input  logic [1:0]       retire_cnt,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] occ,
  output logic             full
);
  logic [CNT_W-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + CNT_W'(retire_cnt);
      if (do_alloc) tail_q <= tail_q + CNT_W'(1);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign occ      = tail_q - head_q;
  assign full     = (occ == CNT_W'(DEPTH));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && retire_cnt == 2'd0 && !flush) |=> full);

  // R9
  dual_needs_two_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_cnt == 2'd2) |-> (occ >= CNT_W'(2)));

  // R4
  retire_needs_live_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_cnt != 2'd0) |-> (occ != '0));
endmodule

// File: rtl/retire_entries.sv
module retire_entries import retire_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         alloc_we,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [1:0]                   alloc_kind,
  input  logic [DEST_W-1:0]            alloc_dest,
  input  logic                         res_valid,
  input  logic [IDX_W-1:0]             res_tag,
  input  logic [DATA_W-1:0]            res_value,
  input  logic                         res_excp,
  input  logic                         res_misp,
  input  logic [IDX_W-1:0]             head_idx,
  input  logic [LANES-1:0]             ret,
  input  logic [CNT_W-1:0]             occ,
  input  logic [IDX_W-1:0]             rd_tag,
  output logic                         rd_hit,
  output logic [DATA_W-1:0]            rd_value,
  output logic [LANES-1:0]             hd_live,
  output logic [LANES-1:0]             hd_ready,
  output logic [LANES-1:0]             hd_excp,
  output logic [LANES-1:0]             hd_misp,
  output logic [LANES-1:0][1:0]        hd_kind,
  output logic [LANES-1:0][DEST_W-1:0] hd_dest,
  output logic [LANES-1:0][DATA_W-1:0] hd_value
);
  logic [DEPTH-1:0]  valid_q, ready_q, excp_q, misp_q;
  logic [1:0]        kind_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic              res_hit;

  assign res_hit = res_valid && valid_q[res_tag] && !flush;

  // Status bits: flops, cleared as a group on flush.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      ready_q <= '0;
      excp_q  <= '0;
      misp_q  <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (ret[l]) valid_q[head_idx + IDX_W'(l)] <= 1'b0;
      end
      if (res_hit) begin
        ready_q[res_tag] <= 1'b1;
        excp_q[res_tag]  <= res_excp;
        misp_q[res_tag]  <= res_misp;
      end
      if (alloc_we) begin
        valid_q[alloc_idx] <= 1'b1;
        ready_q[alloc_idx] <= 1'b0;
        excp_q[alloc_idx]  <= 1'b0;
        misp_q[alloc_idx]  <= 1'b0;
      end
    end
  end

  // Payload arrays: one write port each, no reset.
  always_ff @(posedge clk) begin
    if (alloc_we && !flush) begin
      kind_q[alloc_idx] <= alloc_kind;
      dest_q[alloc_idx] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (res_hit) value_q[res_tag] <= res_value;
  end

  // Registered operand lookup.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit   <= 1'b0;
      rd_value <= '0;
    end else begin
      rd_hit   <= valid_q[rd_tag] && ready_q[rd_tag];
      rd_value <= value_q[rd_tag];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_head
    logic [IDX_W-1:0] slot;
    assign slot        = head_idx + IDX_W'(l);
    assign hd_live[l]  = valid_q[slot];
    assign hd_ready[l] = ready_q[slot];
    assign hd_excp[l]  = excp_q[slot];
    assign hd_misp[l]  = misp_q[slot];
    assign hd_kind[l]  = kind_q[slot];
    assign hd_dest[l]  = dest_q[slot];
    assign hd_value[l] = value_q[slot];
  end

  // R1
  live_count_chk: assert property (@(posedge clk) disable iff (rst)
    CNT_W'($countones(valid_q)) == occ);

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/retire_commit.sv
module retire_commit import retire_pkg::*; #(
  parameter int                DATA_W     = 32,
  parameter int                DEST_W     = 32,
  parameter int                REG_W      = 5,
  parameter logic [DATA_W-1:0] EXC_VECTOR = 'h180
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0]             hd_live,
  input  logic [LANES-1:0]             hd_ready,
  input  logic [LANES-1:0]             hd_excp,
  input  logic [LANES-1:0]             hd_misp,
  input  logic [LANES-1:0][1:0]        hd_kind,
  input  logic [LANES-1:0][DEST_W-1:0] hd_dest,
  input  logic [LANES-1:0][DATA_W-1:0] hd_value,
  output logic [LANES-1:0]             ret,
  output logic [1:0]                   retire_cnt,
  output logic                         flush_now,
  output logic [LANES-1:0]             rf_we,
  output logic [LANES-1:0][REG_W-1:0]  rf_waddr,
  output logic [LANES-1:0][DATA_W-1:0] rf_wdata,
  output logic [LANES-1:0]             mem_we,
  output logic [LANES-1:0][DEST_W-1:0] mem_addr,
  output logic [LANES-1:0][DATA_W-1:0] mem_data,
  output logic                         flush_q,
  output logic                         flush_excp_q,
  output logic [DATA_W-1:0]            flush_target_q
);
  logic [LANES-1:0] lane_ft, lane_done;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ft[l]   = flush_type(hd_kind[l], hd_excp[l], hd_misp[l]);
    assign lane_done[l] = hd_live[l] & hd_ready[l];
  end

  // A lane retires only behind a normally retiring older lane.
  always_comb begin
    ret[0] = lane_done[0] & ~lane_ft[0];
    for (int l = 1; l < LANES; l++) begin
      ret[l] = ret[l-1] & lane_done[l] & ~lane_ft[l];
    end
  end

  assign retire_cnt = 2'($countones(ret));
  assign flush_now  = lane_done[0] & lane_ft[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we          <= '0;
      rf_waddr       <= '0;
      rf_wdata       <= '0;
      mem_we         <= '0;
      mem_addr       <= '0;
      mem_data       <= '0;
      flush_q        <= 1'b0;
      flush_excp_q   <= 1'b0;
      flush_target_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        rf_we[l]    <= ret[l] && (hd_kind[l] == K_REG);
        mem_we[l]   <= ret[l] && (hd_kind[l] == K_STORE);
        rf_waddr[l] <= hd_dest[l][REG_W-1:0];
        rf_wdata[l] <= hd_value[l];
        mem_addr[l] <= hd_dest[l];
        mem_data[l] <= hd_value[l];
      end
      flush_q        <= flush_now;
      flush_excp_q   <= flush_now & hd_excp[0];
      flush_target_q <= hd_excp[0] ? EXC_VECTOR : hd_value[0];
    end
  end

  // R4
  head_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (hd_live[0] && !hd_ready[0]) |=> (rf_we == '0 && mem_we == '0 && !flush_q));

  // R7
  exception_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (hd_live[0] && hd_ready[0] && hd_excp[0]) |=>
      (flush_q && flush_excp_q && rf_we == '0 && mem_we == '0));

  // R6
  mispredict_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (hd_live[0] && hd_ready[0] && !hd_excp[0] && hd_kind[0] == K_BRANCH && hd_misp[0]) |=>
      (flush_q && !flush_excp_q && rf_we == '0 && mem_we == '0));
endmodule

// File: rtl/retire_buffer.sv
module retire_buffer import retire_pkg::*; #(
  parameter int                DEPTH      = 8,
  parameter int                DATA_W     = 32,
  parameter int                DEST_W     = 32,
  parameter int                REG_W      = 5,
  parameter logic [DATA_W-1:0] EXC_VECTOR = 'h180,
  localparam int               IDX_W      = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_valid,
  input  logic [1:0]                   alloc_kind,
  input  logic [DEST_W-1:0]            alloc_dest,
  output logic                         alloc_ready,
  output logic [IDX_W-1:0]             alloc_tag,
  input  logic                         res_valid,
  input  logic [IDX_W-1:0]             res_tag,
  input  logic [DATA_W-1:0]            res_value,
  input  logic                         res_excp,
  input  logic                         res_misp,
  input  logic [IDX_W-1:0]             rd_tag,
  output logic                         rd_hit,
  output logic [DATA_W-1:0]            rd_value,
  output logic [1:0]                   rf_we,
  output logic [1:0][REG_W-1:0]        rf_waddr,
  output logic [1:0][DATA_W-1:0]       rf_wdata,
  output logic [1:0]                   mem_we,
  output logic [1:0][DEST_W-1:0]       mem_addr,
  output logic [1:0][DATA_W-1:0]       mem_data,
  output logic                         flush,
  output logic                         flush_excp,
  output logic [DATA_W-1:0]            flush_target
);
  localparam int CNT_W = IDX_W + 1;

  logic                         full, do_alloc, flush_now;
  logic [IDX_W-1:0]             head_idx, tail_idx;
  logic [CNT_W-1:0]             occ;
  logic [1:0]                   retire_cnt;
  logic [LANES-1:0]             ret, hd_live, hd_ready, hd_excp, hd_misp;
  logic [LANES-1:0][1:0]        hd_kind;
  logic [LANES-1:0][DEST_W-1:0] hd_dest;
  logic [LANES-1:0][DATA_W-1:0] hd_value;

  assign alloc_ready = !full;
  assign alloc_tag   = tail_idx;
  assign do_alloc    = alloc_valid && !full;

  retire_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst(rst), .do_alloc(do_alloc), .retire_cnt(retire_cnt),
    .flush(flush_now), .head_idx(head_idx), .tail_idx(tail_idx),
    .occ(occ), .full(full)
  );

  retire_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W),
                   .DATA_W(DATA_W), .DEST_W(DEST_W)) u_entries (
    .clk(clk), .rst(rst), .flush(flush_now),
    .alloc_we(do_alloc), .alloc_idx(tail_idx), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .res_valid(res_valid), .res_tag(res_tag),
    .res_value(res_value), .res_excp(res_excp), .res_misp(res_misp),
    .head_idx(head_idx), .ret(ret), .occ(occ), .rd_tag(rd_tag),
    .rd_hit(rd_hit), .rd_value(rd_value), .hd_live(hd_live),
    .hd_ready(hd_ready), .hd_excp(hd_excp), .hd_misp(hd_misp),
    .hd_kind(hd_kind), .hd_dest(hd_dest), .hd_value(hd_value)
  );

  retire_commit #(.DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W),
                  .EXC_VECTOR(EXC_VECTOR)) u_commit (
    .clk(clk), .rst(rst), .hd_live(hd_live), .hd_ready(hd_ready),
    .hd_excp(hd_excp), .hd_misp(hd_misp), .hd_kind(hd_kind),
    .hd_dest(hd_dest), .hd_value(hd_value), .ret(ret),
    .retire_cnt(retire_cnt), .flush_now(flush_now),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .flush_q(flush), .flush_excp_q(flush_excp), .flush_target_q(flush_target)
  );
endmodule

// File: tb/sim_retire_buffer.sv
`timescale 1ns/1ps
module sim_retire_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam logic [31:0] EXC = 32'h180;

  // {kind[1:0], dest[31:0], value[31:0]}; kind 0 reg, 1 store, 2 branch
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'h3,   32'h11},
    {2'd1, 32'h100, 32'h22},
    {2'd0, 32'h7,   32'h33},
    {2'd2, 32'h0,   32'h44},
    {2'd1, 32'h104, 32'h55},
    {2'd0, 32'h1,   32'h66},
    {2'd0, 32'h2,   32'h77},
    {2'd1, 32'h108, 32'h88}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, res_valid = 0, res_excp = 0, res_misp = 0;
  logic [1:0] alloc_kind = 0;
  logic [31:0] alloc_dest = 0, res_value = 0;
  logic [IDX_W-1:0] res_tag = 0, rd_tag = 0;
  logic alloc_ready, rd_hit, flush, flush_excp;
  logic [IDX_W-1:0] alloc_tag;
  logic [31:0] rd_value, flush_target;
  logic [1:0] rf_we, mem_we;
  logic [1:0][4:0] rf_waddr;
  logic [1:0][31:0] rf_wdata, mem_addr, mem_data;

  retire_buffer #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .res_excp(res_excp), .res_misp(res_misp), .rd_tag(rd_tag),
    .rd_hit(rd_hit), .rd_value(rd_value), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .flush(flush), .flush_excp(flush_excp),
    .flush_target(flush_target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, nlog = 0, dual_cnt = 0, flush_cnt = 0, flush_cyc = 0;
  logic        flush_ex_seen = 0;
  logic [31:0] flush_tgt_seen = 0;
  logic        log_st [32];
  logic [31:0] log_ad [32];
  logic [31:0] log_dt [32];
  int          log_cy [32];

  // Monitor, one time unit after each rising edge.
  always begin
    @(posedge clk);
    #1;
    cyc++;
    for (int l = 0; l < 2; l++) begin
      if (rf_we[l] && nlog < 32) begin
        log_st[nlog] = 0; log_ad[nlog] = 32'(rf_waddr[l]);
        log_dt[nlog] = rf_wdata[l]; log_cy[nlog] = cyc; nlog++;
      end
      if (mem_we[l] && nlog < 32) begin
        log_st[nlog] = 1; log_ad[nlog] = mem_addr[l];
        log_dt[nlog] = mem_data[l]; log_cy[nlog] = cyc; nlog++;
      end
    end
    if (rf_we[1] || mem_we[1]) dual_cnt++;
    if (flush) begin
      flush_cnt++; flush_ex_seen = flush_excp;
      flush_tgt_seen = flush_target; flush_cyc = cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc_one(input logic [1:0] k, input logic [31:0] d);
    alloc_valid = 1; alloc_kind = k; alloc_dest = d;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic send_res(input int t, input logic [31:0] v, input logic ex, input logic mp);
    res_valid = 1; res_tag = IDX_W'(t); res_value = v; res_excp = ex; res_misp = mp;
    @(negedge clk);
    res_valid = 0; res_excp = 0; res_misp = 0;
  endtask

  task automatic lookup(input int t);
    rd_tag = IDX_W'(t);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", 32'(alloc_ready), 1);
    chk("R1 tag after reset", 32'(alloc_tag), 0);
    chk("R1 rf_we after reset", 32'(rf_we), 0);
    chk("R1 mem_we after reset", 32'(mem_we), 0);
    chk("R1 flush after reset", 32'(flush), 0);

    // Vector walk: fill the buffer in order
    for (int i = 0; i < 8; i++) begin
      chk("R1 sequential tag", 32'(alloc_tag), 32'(i));
      alloc_one(VEC[i][65:64], VEC[i][63:32]);
    end
    chk("R2 full blocks issue", 32'(alloc_ready), 0);
    alloc_one(2'd0, 32'h1f);            // must be ignored while full
    lookup(2);
    chk("R8 lookup not ready", 32'(rd_hit), 0);
    // Results arrive youngest first
    for (int i = 7; i >= 1; i--) send_res(i, VEC[i][31:0], 0, 0);
    idle(2);
    chk("R4 nothing retires behind waiting head", 32'(nlog), 0);
    lookup(5);
    chk("R8 lookup hit", 32'(rd_hit), 1);
    chk("R8 lookup value", rd_value, 32'h66);
    send_res(0, VEC[0][31:0], 0, 0);
    idle(8);
    chk("R5 write count", 32'(nlog), 7);
    base = 0;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][65:64] != 2'd2) begin
        chk("R5 write kind", 32'(log_st[base]), 32'(VEC[i][65:64] == 2'd1));
        chk("R5 write addr", log_ad[base],
            VEC[i][65:64] == 2'd0 ? {27'd0, VEC[i][36:32]} : VEC[i][63:32]);
        chk("R5 write data", log_dt[base], VEC[i][31:0]);
        base++;
      end
    end
    chk("R9 cycles with two lanes writing", 32'(dual_cnt), 3);
    chk("R9 first two retire together", 32'(log_cy[1] - log_cy[0]), 0);
    chk("R2 ready after retire", 32'(alloc_ready), 1);
    chk("R1 tag wraps", 32'(alloc_tag), 0);

    // Mispredicted branch
    alloc_one(2'd0, 32'h4);
    alloc_one(2'd2, 32'h0);
    alloc_one(2'd0, 32'h5);
    send_res(2, 32'h5c, 0, 0);
    send_res(0, 32'h4a, 0, 0);
    send_res(1, 32'h500, 0, 1);
    idle(4);
    chk("R6 older entry written", 32'(nlog), 8);
    chk("R6 older entry data", log_dt[7], 32'h4a);
    chk("R6 flush count", 32'(flush_cnt), 1);
    chk("R6 flush cause", 32'(flush_ex_seen), 0);
    chk("R6 flush target", flush_tgt_seen, 32'h500);
    chk("R6 tag restarts", 32'(alloc_tag), 0);
    lookup(2);
    chk("R6 wrong-path entry gone", 32'(rd_hit), 0);

    // Exception in second place
    alloc_one(2'd0, 32'h6);
    alloc_one(2'd1, 32'h200);
    alloc_one(2'd0, 32'h8);
    send_res(1, 32'h77, 1, 0);
    send_res(2, 32'h88, 0, 0);
    idle(3);
    chk("R7 exception waits for head", 32'(flush_cnt), 1);
    chk("R4 no write before head", 32'(nlog), 8);
    send_res(0, 32'h66, 0, 0);
    idle(4);
    chk("R7 only older entry written", 32'(nlog), 9);
    chk("R7 older data", log_dt[8], 32'h66);
    chk("R7 flush count", 32'(flush_cnt), 2);
    chk("R7 flush cause", 32'(flush_ex_seen), 1);
    chk("R7 flush target", flush_tgt_seen, EXC);
    chk("R10 flush one clock after head", 32'(flush_cyc - log_cy[8]), 1);

    // Result to a dead tag
    send_res(0, 32'h12, 0, 0);
    alloc_one(2'd0, 32'h9);
    idle(3);
    chk("R3 stray result ignored", 32'(nlog), 9);
    lookup(0);
    chk("R3 entry still waiting", 32'(rd_hit), 0);
    send_res(0, 32'h99, 0, 0);
    idle(3);
    chk("R3 live result retires", 32'(nlog), 10);
    chk("R3 live result data", log_dt[9], 32'h99);
    chk("R3 live result addr", log_ad[9], 32'h9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule